// File: doc/BRIEF.md
# Fabric Error Detect and Capture Unit

This block collects error events from an interconnect fabric and presents them to software through a small 32-bit register port. Each cycle the fabric may pulse any of four error classes: local access error, coherency violation, unavailable target, and multicast stash. With each class come the address, source ID and transaction type code of the transfer that caused it. Each class that is not disabled sets a sticky detect bit. The first error seen while no capture is held also freezes its 40-bit address, source ID and type code in capture registers, and sets a capture-valid flag.

A separate per-class interrupt-enable mask decides which pending classes drive the level interrupt, so an error can be logged without being signalled. Software clears the detect bits and the capture-valid flag by writing ones to them. The usual handler reads the detect register and writes the same value back. Once capture-valid is clear, the next error can be captured.

Top module: `fab_err_unit`

## Requirements
- R1: After reset every register reads zero and `irq_o` is low.
- R2: A pulse on `evt_i[c]` while disable bit c is clear sets detect bit c (offset 0x00) on the next clock edge. The bit then stays set until software clears it. Class bits are: 0 local access, 1 coherency violation, 2 unavailable target, 3 multicast stash.
- R3: While disable bit c (offset 0x04, bits 3:0) is set, pulses on `evt_i[c]` leave detect bit c clear and start no capture.
- R4: `irq_o` is high exactly when some detect bit is set and the interrupt-enable bit at the same position (offset 0x08, bits 3:0) is also set.
- R5: A write to offset 0x00 clears each detect bit (3:0) and the capture-valid flag (bit 31) that is written as one. Bits written as zero keep their value.
- R6: If an event and a software clear hit the same detect bit in the same cycle, the bit stays set. A capture that arrives in the cycle that clears capture-valid is taken, and capture-valid stays set.
- R7: When capture-valid is clear and an enabled event occurs, the unit loads these fields and sets capture-valid (0x00 bit 31). The type code goes to 0x00 bits 30:26 and the source ID to 0x0C bits 25:18. Address bits 39:32 go to 0x10 bits 7:0 and address bits 31:0 go to 0x14.
- R8: While capture-valid is set, further events update only the detect bits. The captured type, source ID, address and class set keep their values.
- R9: When several enabled events arrive in the cycle that captures, the lowest-numbered class supplies the type, source ID and address.
- R10: Reserved bits and unmapped offsets read as zero, and writes to them have no effect. The capture registers (0x0C, 0x10, 0x14, 0x18) are read-only.
- R11: Offset 0x18 bits 3:0 hold the set of enabled classes that fired in the capture cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_i | input | 4 | Error event pulses, one per class |
| evt_addr_i | input | 160 | Per-class 40-bit address, class c at [c*40 +: 40] |
| evt_src_i | input | 32 | Per-class 8-bit source ID, class c at [c*8 +: 8] |
| evt_type_i | input | 20 | Per-class 5-bit type code, class c at [c*5 +: 5] |
| reg_addr_i | input | 5 | Register byte offset |
| reg_we_i | input | 1 | Write strobe |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for `reg_addr_i`, combinational |
| irq_o | output | 1 | Level interrupt |

## Verification
The hardest case to reach is a collision: an event lands in the same cycle that software writes a clear to its detect bit or to capture-valid, while other classes fire at the same moment. Random traffic alone rarely lines these up. The bench therefore places such collisions deliberately, together with multi-class bursts, and then runs a long random phase. That phase biases writes toward the detect offset so that clears and events keep overlapping.

// File: rtl/fab_err_pkg.sv
package fab_err_pkg;
  localparam int unsigned CLS_N    = 4;
  localparam logic [4:0]  OFF_DET  = 5'h00;
  localparam logic [4:0]  OFF_DIS  = 5'h04;
  localparam logic [4:0]  OFF_IEN  = 5'h08;
  localparam logic [4:0]  OFF_ATTR = 5'h0C;
  localparam logic [4:0]  OFF_AHI  = 5'h10;
  localparam logic [4:0]  OFF_ALO  = 5'h14;
  localparam logic [4:0]  OFF_SET  = 5'h18;
  localparam int unsigned CV_BIT   = 31;
  localparam int unsigned TYPE_LSB = 26;
  localparam int unsigned SRC_LSB  = 18;
endpackage

// File: rtl/fab_err_prio.sv
module fab_err_prio #(
  parameter int unsigned N  = 4,
  localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req_i,
  output logic [IW-1:0] idx_o
);
  // lowest index wins
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IW'(i);
    end
  end
endmodule

// File: rtl/fab_err_status.sv
module fab_err_status #(
  parameter int unsigned N = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] hit_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] det_o
);
  for (genvar c = 0; c < N; c++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        det_o[c] <= 1'b0;
      else if (hit_i[c])  det_o[c] <= 1'b1;  // set beats clear
      else if (clr_i[c])  det_o[c] <= 1'b0;
    end
  end
endmodule

// File: rtl/fab_err_capture.sv
module fab_err_capture #(
  parameter int unsigned N      = 4,
  parameter int unsigned ADDR_W = 40,
  parameter int unsigned SRC_W  = 8,
  parameter int unsigned TYPE_W = 5,
  localparam int unsigned IW    = (N > 1) ? $clog2(N) : 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [N-1:0]        hit_i,
  input  logic [N*ADDR_W-1:0] addr_i,
  input  logic [N*SRC_W-1:0]  src_i,
  input  logic [N*TYPE_W-1:0] type_i,
  input  logic                clr_i,
  output logic                cv_o,
  output logic [ADDR_W-1:0]   addr_o,
  output logic [SRC_W-1:0]    src_o,
  output logic [TYPE_W-1:0]   type_o,
  output logic [N-1:0]        set_o
);
  logic [IW-1:0] sel;
  logic          take;

  fab_err_prio #(.N(N)) i_prio (.req_i(hit_i), .idx_o(sel));

  assign take = (|hit_i) && (!cv_o || clr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cv_o   <= 1'b0;
      addr_o <= '0;
      src_o  <= '0;
      type_o <= '0;
      set_o  <= '0;
    end else if (take) begin
      cv_o   <= 1'b1;
      addr_o <= addr_i[sel*ADDR_W +: ADDR_W];
      src_o  <= src_i[sel*SRC_W +: SRC_W];
      type_o <= type_i[sel*TYPE_W +: TYPE_W];
      set_o  <= hit_i;
    end else if (clr_i) begin
      cv_o   <= 1'b0;
    end
  end
endmodule

// File: rtl/fab_err_unit.sv
module fab_err_unit
  import fab_err_pkg::*;
#(
  parameter int unsigned ADDR_W = 40,
  parameter int unsigned SRC_W  = 8,
  parameter int unsigned TYPE_W = 5
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [CLS_N-1:0]        evt_i,
  input  logic [CLS_N*ADDR_W-1:0] evt_addr_i,
  input  logic [CLS_N*SRC_W-1:0]  evt_src_i,
  input  logic [CLS_N*TYPE_W-1:0] evt_type_i,
  input  logic [4:0]              reg_addr_i,
  input  logic                    reg_we_i,
  input  logic [31:0]             reg_wdata_i,
  output logic [31:0]             reg_rdata_o,
  output logic                    irq_o
);
  localparam int unsigned HI_W = ADDR_W - 32;

  logic [CLS_N-1:0]  dis_q, ien_q, det_q, hit, det_clr, cap_set;
  logic              cap_v, cap_clr, wr_det;
  logic [ADDR_W-1:0] cap_addr;
  logic [SRC_W-1:0]  cap_src;
  logic [TYPE_W-1:0] cap_type;
  logic              unused_wdata;

  assign unused_wdata = ^reg_wdata_i[30:CLS_N];
  assign hit     = evt_i & ~dis_q;
  assign wr_det  = reg_we_i && (reg_addr_i == OFF_DET);
  assign det_clr = wr_det ? reg_wdata_i[CLS_N-1:0] : '0;
  assign cap_clr = wr_det && reg_wdata_i[CV_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dis_q <= '0;
      ien_q <= '0;
    end else if (reg_we_i) begin
      if (reg_addr_i == OFF_DIS) dis_q <= reg_wdata_i[CLS_N-1:0];
      if (reg_addr_i == OFF_IEN) ien_q <= reg_wdata_i[CLS_N-1:0];
    end
  end

  fab_err_status #(.N(CLS_N)) i_status (
    .clk_i, .rst_ni, .hit_i(hit), .clr_i(det_clr), .det_o(det_q)
  );

  fab_err_capture #(
    .N(CLS_N), .ADDR_W(ADDR_W), .SRC_W(SRC_W), .TYPE_W(TYPE_W)
  ) i_capture (
    .clk_i, .rst_ni,
    .hit_i(hit), .addr_i(evt_addr_i), .src_i(evt_src_i), .type_i(evt_type_i),
    .clr_i(cap_clr), .cv_o(cap_v), .addr_o(cap_addr), .src_o(cap_src),
    .type_o(cap_type), .set_o(cap_set)
  );

  assign irq_o = |(det_q & ien_q);

  always_comb begin
    reg_rdata_o = '0;
    unique case (reg_addr_i)
      OFF_DET: begin
        reg_rdata_o[CLS_N-1:0]            = det_q;
        reg_rdata_o[TYPE_LSB +: TYPE_W]   = cap_type;
        reg_rdata_o[CV_BIT]               = cap_v;
      end
      OFF_DIS:  reg_rdata_o[CLS_N-1:0]       = dis_q;
      OFF_IEN:  reg_rdata_o[CLS_N-1:0]       = ien_q;
      OFF_ATTR: reg_rdata_o[SRC_LSB +: SRC_W] = cap_src;
      OFF_AHI:  reg_rdata_o[HI_W-1:0]        = cap_addr[ADDR_W-1:32];
      OFF_ALO:  reg_rdata_o                  = cap_addr[31:0];
      OFF_SET:  reg_rdata_o[CLS_N-1:0]       = cap_set;
      default:  reg_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/fab_err_chk.sv
module fab_err_chk #(
  parameter int unsigned N      = 4,
  parameter int unsigned ADDR_W = 40
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [N-1:0]      evt_i,
  input logic [N-1:0]      dis_i,
  input logic [N-1:0]      det_i,
  input logic              cap_v_i,
  input logic              cap_clr_i,
  input logic [ADDR_W-1:0] cap_addr_i,
  input logic              irq_i
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk_i)
    !rst_ni |-> (!irq_i && det_i == '0 && !cap_v_i));

  // R2
  event_latched_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (($past(evt_i & ~dis_i)) & ~det_i) == '0);

  // R3
  disabled_no_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((det_i & ~$past(det_i)) & $past(dis_i)) == '0);

  // R4
  irq_needs_pending_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_i |-> (det_i != '0));

  // R7
  capture_has_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cap_v_i) |-> ($past(evt_i & ~dis_i) != '0));

  // R8
  capture_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_v_i && !cap_clr_i) |=> $stable(cap_addr_i));
endmodule

bind fab_err_unit fab_err_chk #(.N(fab_err_pkg::CLS_N), .ADDR_W(ADDR_W)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .evt_i(evt_i), .dis_i(dis_q), .det_i(det_q),
  .cap_v_i(cap_v), .cap_clr_i(cap_clr), .cap_addr_i(cap_addr), .irq_i(irq_o)
);

// File: tb/test_fab_err_unit.sv
module test_fab_err_unit;
  localparam int AW = 40, SW = 8, TW = 5, NC = 4;
  localparam time CYC = 20ns;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NC-1:0] evt;
  logic [NC*AW-1:0] eaddr;
  logic [NC*SW-1:0] esrc;
  logic [NC*TW-1:0] etype;
  logic [4:0] raddr;
  logic we;
  logic [31:0] wdata, rdata;
  logic irq;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  logic [NC-1:0] m_det, m_dis, m_ien, m_set;
  logic m_cv;
  logic [TW-1:0] m_type;
  logic [SW-1:0] m_src;
  logic [AW-1:0] m_addr;

  always #(CYC/2) clk = ~clk;

  fab_err_unit i_fab_err_unit (
    .clk_i(clk), .rst_ni(rst_n), .evt_i(evt), .evt_addr_i(eaddr),
    .evt_src_i(esrc), .evt_type_i(etype), .reg_addr_i(raddr), .reg_we_i(we),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq)
  );

  function automatic logic [31:0] exp_rd(logic [4:0] a);
    logic [31:0] v = '0;
    case (a)
      5'h00: begin v[3:0] = m_det; v[30:26] = m_type; v[31] = m_cv; end
      5'h04: v[3:0] = m_dis;
      5'h08: v[3:0] = m_ien;
      5'h0C: v[25:18] = m_src;
      5'h10: v[7:0] = m_addr[39:32];
      5'h14: v = m_addr[31:0];
      5'h18: v[3:0] = m_set;
      default: v = '0;
    endcase
    return v;
  endfunction

  function automatic string tag_of(logic [4:0] a);
    case (a)
      5'h00: return "R2/R5/R7";
      5'h04, 5'h08: return "R10";
      5'h0C, 5'h10, 5'h14: return "R7/R8";
      5'h18: return "R11";
      default: return "R10";
    endcase
  endfunction

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
    end
  endtask

  task automatic rd(logic [4:0] a, output logic [31:0] v);
    raddr = a; #1; v = rdata;
  endtask

  task automatic check_all();
    logic [31:0] v;
    for (int i = 0; i < 8; i++) begin
      rd(5'(i * 4), v);
      chk(tag_of(5'(i * 4)), v, exp_rd(5'(i * 4)));
    end
    chk("R4", {31'b0, irq}, {31'b0, |(m_det & m_ien)});
  endtask

  task automatic step(logic [3:0] ev, logic w, logic [4:0] a, logic [31:0] wd);
    logic [3:0] hit, clr;
    logic eff;
    int lo;
    @(negedge clk);
    for (int c = 0; c < NC; c++) begin
      eaddr[c*AW +: AW] = {$urandom, $urandom};
      esrc[c*SW +: SW]  = SW'($urandom);
      etype[c*TW +: TW] = TW'($urandom);
    end
    evt = ev; we = w; raddr = a; wdata = wd;
    @(posedge clk); #1;
    hit = ev & ~m_dis;
    clr = (w && a == 5'h00) ? wd[3:0] : 4'h0;
    eff = m_cv & ~(w && a == 5'h00 && wd[31]);
    m_det = (m_det & ~clr) | hit;
    if (hit != 0 && !eff) begin
      lo = 0;
      for (int c = NC - 1; c >= 0; c--) if (hit[c]) lo = c;
      m_cv = 1'b1; m_set = hit;
      m_addr = eaddr[lo*AW +: AW]; m_src = esrc[lo*SW +: SW];
      m_type = etype[lo*TW +: TW];
    end else m_cv = eff;
    if (w && a == 5'h04) m_dis = wd[3:0];
    if (w && a == 5'h08) m_ien = wd[3:0];
    evt = '0; we = 1'b0;
    check_all();
  endtask

  initial begin
    #(CYC * 200000);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] v, keep;
    void'($urandom(32'd2024));
    evt = '0; eaddr = '0; esrc = '0; etype = '0; raddr = '0; we = 0; wdata = '0;
    m_det = '0; m_dis = '0; m_ien = '0; m_set = '0; m_cv = 0;
    m_type = '0; m_src = '0; m_addr = '0;
    #(CYC * 3);
    check_all();  // R1: all zero in reset
    chk("R1", {31'b0, irq}, 32'd0);
    @(negedge clk); rst_n = 1'b1;

    step(4'h0, 1, 5'h08, 32'h0000_000F);
    step(4'b0010, 0, 5'h00, 0);
    rd(5'h00, v); chk("R2", v & 32'h8000_000F, 32'h8000_0002);
    chk("R4", {31'b0, irq}, 32'd1);
    rd(5'h14, keep);
    step(4'b0001, 0, 5'h00, 0);
    rd(5'h14, v); chk("R8", v, keep);
    rd(5'h00, v);
    step(4'h0, 1, 5'h00, 32'h0);
    rd(5'h00, keep); chk("R5", keep, v);
    step(4'h0, 1, 5'h00, v);
    rd(5'h00, v); chk("R5", v & 32'h8000_000F, 32'h0);
    chk("R4", {31'b0, irq}, 32'd0);

    step(4'h0, 1, 5'h04, 32'h0000_0004);
    step(4'b0100, 0, 5'h00, 0);
    rd(5'h00, v); chk("R3", v & 32'h8000_000F, 32'h0);
    step(4'h0, 1, 5'h04, 32'h0);

    step(4'b0001, 0, 5'h00, 0);
    step(4'b0001, 1, 5'h00, 32'h8000_0001);
    rd(5'h00, v); chk("R6", v & 32'h8000_000F, 32'h8000_0001);
    step(4'h0, 1, 5'h00, 32'h8000_000F);

    step(4'b1010, 0, 5'h00, 0);
    rd(5'h18, v); chk("R11", v, 32'h0000_000A);
    rd(5'h0C, v); chk("R9", v, {6'b0, m_src, 18'b0});
    chk("R9", {24'b0, m_src}, {24'b0, esrc[1*SW +: SW]});
    rd(5'h00, v); chk("R9", {27'b0, v[30:26]}, {27'b0, etype[1*TW +: TW]});
    step(4'h0, 1, 5'h00, 32'h8000_000F);

    step(4'h0, 1, 5'h04, 32'hFFFF_FFF0);
    rd(5'h04, v); chk("R10", v, 32'h0);
    rd(5'h14, keep);
    step(4'h0, 1, 5'h14, 32'hDEAD_BEEF);
    rd(5'h14, v); chk("R10", v, keep);
    step(4'h0, 1, 5'h1C, 32'hFFFF_FFFF);
    rd(5'h1C, v); chk("R10", v, 32'h0);

    for (int k = 0; k < 3000; k++) begin
      int r = $urandom_range(0, 9);
      logic [3:0] ev = ($urandom_range(0, 2) == 0) ? 4'($urandom) : 4'h0;
      logic [4:0] a = (r < 5) ? 5'h00 : (r < 7) ? 5'h04 : (r < 9) ? 5'h08 : 5'h14;
      step(ev, $urandom_range(0, 2) == 0, a, $urandom);
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule